// File: doc/BRIEF.md
# Access Wait-State Cycle Calculator

This block works out how many extra wait cycles a single bus access costs. For each access it takes the top byte of the address, the access width, a flag that marks the access as sequential, a flag that is high while the display is in its horizontal drawing period, and the cartridge wait-control selector fields. One clock later it returns a 4-bit cycle count together with a valid strobe. A bus interface loads that count into its stall counter.

The cost depends on several inputs at once:

- **External work RAM** has a fixed cost that depends on width.
- **Display memories** cost extra while the display is drawing.
- **Cartridge window** looks its cost up in two programmable timing tables, chosen by whether the access is sequential.
- **Two further cartridge windows** are not timed. They raise an error flag.
- **All other regions** cost nothing.

The calculator is a two-state machine:

- **ST_IDLE**: no result is being presented.
- **ST_REPORT**: a result is on the outputs.

Transitions:

- **T_ACCEPT** (ST_IDLE to ST_REPORT) when `req_valid` is high.
- **T_STREAM** (ST_REPORT to ST_REPORT) when another request arrives straight after the last one.
- **T_DRAIN** (ST_REPORT to ST_IDLE) when `req_valid` is low.
- **T_WAIT** (ST_IDLE to ST_IDLE) when `req_valid` stays low.

Top module: `wsc_top`

## Requirements
- R1: Top byte 0x02 costs 3 cycles for a narrow access and 6 cycles for a word access. The width codes are 2'b00 byte, 2'b01 halfword and 2'b10 word; code 2'b11 is treated as narrow.
- R2: Top bytes 0x05, 0x06 and 0x07 cost 1 cycle when narrow and 2 cycles when word. One more cycle is added when `disp_hdraw` is high.
- R3: A non-sequential (`req_seq`=0) access to top byte 0x08 costs the first-access value. The first-access table is {4,3,2,8}, indexed by `cart_first_sel` values 0 to 3. A word access also adds the second-access value.
- R4: A sequential (`req_seq`=1) access to top byte 0x08 costs the second-access value. The second-access table is {2,1}, indexed by `cart_second_sel`. A word access costs twice that value.
- R5: Every other top byte (for example 0x00, 0x03, 0x04, 0x09) costs 0 cycles and does not set the error flag. `disp_hdraw` has no effect on these regions.
- R6: Top bytes 0x0A and 0x0C report 0 cycles with `cyc_unsup` high.
- R7: The result appears on the clock edge after a request, with `cyc_valid` high in that same cycle. Back-to-back requests give back-to-back results.
- R8: In a cycle that follows no request, `cyc_valid` is low, `cyc_count` is 0 and `cyc_unsup` is low.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access descriptor valid this cycle |
| req_tag | input | 8 | Address top byte |
| req_width | input | 2 | Width code: 00 byte, 01 half, 10 word |
| req_seq | input | 1 | 1 = sequential access |
| disp_hdraw | input | 1 | Display is in horizontal drawing period |
| cart_first_sel | input | 2 | Cartridge first-access table index |
| cart_second_sel | input | 1 | Cartridge second-access table index |
| cyc_valid | output | 1 | Result strobe |
| cyc_count | output | 4 | Extra wait cycles |
| cyc_unsup | output | 1 | Untimed cartridge window accessed |

## Verification
The bench covers every entry of both cartridge tables, in both sequential and non-sequential form. It also drives the worst case, a non-sequential word access with selector 3 (8+2=10). A design that added the second value on narrow accesses, or doubled the wrong term, would return the wrong count there. The hdraw penalty is applied on display memories and also on a zero-cost region, so a decoder that added it everywhere would be caught. The untimed windows and 0x09 are checked side by side to confirm that only 0x0A and 0x0C raise the flag. A run of requests followed by an idle gap shows whether the strobe lags, sticks or drops a result.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
    typedef enum logic [2:0] {
        RG_NONE,
        RG_EXTRAM,
        RG_DISP,
        RG_CART,
        RG_UNSUP
    } region_e;

    typedef enum logic {
        ST_IDLE,
        ST_REPORT
    } state_e;

    localparam logic [1:0] WIDTH_WORD = 2'b10;
endpackage

// File: rtl/wsc_region_decode.sv
module wsc_region_decode
    import wsc_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter logic [TAG_W-1:0] TAG_EXTRAM = 8'h02,
    parameter logic [TAG_W-1:0] TAG_PAL    = 8'h05,
    parameter logic [TAG_W-1:0] TAG_VID    = 8'h06,
    parameter logic [TAG_W-1:0] TAG_OBJ    = 8'h07,
    parameter logic [TAG_W-1:0] TAG_CART0  = 8'h08,
    parameter logic [TAG_W-1:0] TAG_CART1  = 8'h0A,
    parameter logic [TAG_W-1:0] TAG_CART2  = 8'h0C
) (
    input  logic [TAG_W-1:0] tag,
    output region_e          cls
);
    always_comb begin
        if (tag == TAG_EXTRAM)
            cls = RG_EXTRAM;
        else if (tag == TAG_PAL || tag == TAG_VID || tag == TAG_OBJ)
            cls = RG_DISP;
        else if (tag == TAG_CART0)
            cls = RG_CART;
        else if (tag == TAG_CART1 || tag == TAG_CART2)
            cls = RG_UNSUP;
        else
            cls = RG_NONE;
    end
endmodule

// File: rtl/wsc_cart_cost.sv
module wsc_cart_cost #(
    parameter int CNT_W = 4,
    parameter int FSEL_W = 2
) (
    input  logic [FSEL_W-1:0] first_sel,
    input  logic              second_sel,
    input  logic              seq,
    input  logic              wide,
    output logic [CNT_W-1:0]  cost
);
    function automatic logic [CNT_W-1:0] first_lut(input logic [FSEL_W-1:0] s);
        logic [CNT_W-1:0] v;
        unique case (s)
            2'd0:    v = CNT_W'(4);
            2'd1:    v = CNT_W'(3);
            2'd2:    v = CNT_W'(2);
            default: v = CNT_W'(8);
        endcase
        return v;
    endfunction

    function automatic logic [CNT_W-1:0] second_lut(input logic s);
        return s ? CNT_W'(1) : CNT_W'(2);
    endfunction

    logic [CNT_W-1:0] first_c;
    logic [CNT_W-1:0] second_c;
    logic [CNT_W-1:0] lead_c;
    logic [CNT_W-1:0] tail_c;

    always_comb begin
        first_c  = first_lut(first_sel);
        second_c = second_lut(second_sel);
        lead_c   = seq ? second_c : first_c;
        tail_c   = wide ? second_c : '0;
        cost     = lead_c + tail_c;
    end
endmodule

// File: rtl/wsc_top.sv
module wsc_top
    import wsc_pkg::*;
#(
    parameter int TAG_W  = 8,
    parameter int CNT_W  = 4,
    parameter int FSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [1:0]        req_width,
    input  logic              req_seq,
    input  logic              disp_hdraw,
    input  logic [FSEL_W-1:0] cart_first_sel,
    input  logic              cart_second_sel,
    output logic              cyc_valid,
    output logic [CNT_W-1:0]  cyc_count,
    output logic              cyc_unsup
);
    localparam int MAX_COST = 10;

    region_e          cls;
    logic             wide;
    logic [CNT_W-1:0] cart_c;
    logic [CNT_W-1:0] cost_d;
    state_e           state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             unsup_q;

    assign wide = (req_width == WIDTH_WORD);

    wsc_region_decode #(.TAG_W(TAG_W)) u_dec (
        .tag (req_tag),
        .cls (cls)
    );

    wsc_cart_cost #(.CNT_W(CNT_W), .FSEL_W(FSEL_W)) u_cart (
        .first_sel  (cart_first_sel),
        .second_sel (cart_second_sel),
        .seq        (req_seq),
        .wide       (wide),
        .cost       (cart_c)
    );

    always_comb begin
        unique case (cls)
            RG_EXTRAM: cost_d = wide ? CNT_W'(6) : CNT_W'(3);
            RG_DISP:   cost_d = (wide ? CNT_W'(2) : CNT_W'(1)) + CNT_W'(disp_hdraw);
            RG_CART:   cost_d = cart_c;
            default:   cost_d = '0;
        endcase
    end

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_REPORT : ST_IDLE;    // T_ACCEPT / T_WAIT
            ST_REPORT: state_d = req_valid ? ST_REPORT : ST_IDLE;    // T_STREAM / T_DRAIN
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            unsup_q <= 1'b0;
        end else begin
            count_q <= req_valid ? cost_d : '0;
            unsup_q <= req_valid && (cls == RG_UNSUP);
        end
    end

    assign cyc_valid = (state_q == ST_REPORT);
    assign cyc_count = count_q;
    assign cyc_unsup = unsup_q;

    AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> cyc_valid); // R7
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!cyc_valid && cyc_count == '0 && !cyc_unsup)); // R8
    AST_UNSUP_NO_COST: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_unsup |-> (cyc_count == '0)); // R6
    AST_EXTRAM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_tag == 8'h02 && req_width == 2'b10) |=> (cyc_count == CNT_W'(6))); // R1
    AST_DISP_DRAW_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_tag == 8'h06 && req_width == 2'b01 && disp_hdraw) |=> (cyc_count == CNT_W'(2))); // R2
    AST_CART_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_tag == 8'h08) |=> (cyc_count >= CNT_W'(1) && cyc_count <= CNT_W'(MAX_COST))); // R3
endmodule

// File: tb/wsc_top_tb.sv
module wsc_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_tag = '0;
    logic [1:0] req_width = '0;
    logic       req_seq = 1'b0;
    logic       disp_hdraw = 1'b0;
    logic [1:0] cart_first_sel = '0;
    logic       cart_second_sel = 1'b0;
    logic       cyc_valid;
    logic [3:0] cyc_count;
    logic       cyc_unsup;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    wsc_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
        .req_width(req_width), .req_seq(req_seq), .disp_hdraw(disp_hdraw),
        .cart_first_sel(cart_first_sel), .cart_second_sel(cart_second_sel),
        .cyc_valid(cyc_valid), .cyc_count(cyc_count), .cyc_unsup(cyc_unsup)
    );

    // {tag[19:12], width[11:10], seq[9], hdraw[8], fsel[7:6], ssel[5], exp_cnt[4:1], exp_unsup[0]}
    localparam int NV = 26;
    localparam logic [19:0] VEC [NV] = '{
        {8'h02, 2'b00, 1'b0, 1'b0, 2'd0, 1'b0, 4'd3,  1'b0}, // R1
        {8'h02, 2'b01, 1'b1, 1'b1, 2'd0, 1'b0, 4'd3,  1'b0}, // R1
        {8'h02, 2'b10, 1'b0, 1'b0, 2'd0, 1'b0, 4'd6,  1'b0}, // R1
        {8'h02, 2'b11, 1'b0, 1'b0, 2'd0, 1'b0, 4'd3,  1'b0}, // R1
        {8'h05, 2'b01, 1'b0, 1'b0, 2'd0, 1'b0, 4'd1,  1'b0}, // R2
        {8'h06, 2'b10, 1'b0, 1'b0, 2'd0, 1'b0, 4'd2,  1'b0}, // R2
        {8'h07, 2'b00, 1'b0, 1'b1, 2'd0, 1'b0, 4'd2,  1'b0}, // R2
        {8'h05, 2'b10, 1'b1, 1'b1, 2'd0, 1'b0, 4'd3,  1'b0}, // R2
        {8'h08, 2'b01, 1'b0, 1'b0, 2'd0, 1'b0, 4'd4,  1'b0}, // R3
        {8'h08, 2'b00, 1'b0, 1'b1, 2'd1, 1'b0, 4'd3,  1'b0}, // R3
        {8'h08, 2'b01, 1'b0, 1'b0, 2'd2, 1'b1, 4'd2,  1'b0}, // R3
        {8'h08, 2'b00, 1'b0, 1'b0, 2'd3, 1'b0, 4'd8,  1'b0}, // R3
        {8'h08, 2'b10, 1'b0, 1'b0, 2'd3, 1'b0, 4'd10, 1'b0}, // R3
        {8'h08, 2'b10, 1'b0, 1'b0, 2'd1, 1'b1, 4'd4,  1'b0}, // R3
        {8'h08, 2'b00, 1'b1, 1'b0, 2'd3, 1'b0, 4'd2,  1'b0}, // R4
        {8'h08, 2'b01, 1'b1, 1'b0, 2'd0, 1'b1, 4'd1,  1'b0}, // R4
        {8'h08, 2'b10, 1'b1, 1'b0, 2'd2, 1'b0, 4'd4,  1'b0}, // R4
        {8'h08, 2'b10, 1'b1, 1'b1, 2'd3, 1'b1, 4'd2,  1'b0}, // R4
        {8'h00, 2'b10, 1'b0, 1'b1, 2'd0, 1'b0, 4'd0,  1'b0}, // R5
        {8'h03, 2'b10, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0,  1'b0}, // R5
        {8'h04, 2'b01, 1'b0, 1'b1, 2'd0, 1'b0, 4'd0,  1'b0}, // R5
        {8'h09, 2'b10, 1'b0, 1'b0, 2'd3, 1'b0, 4'd0,  1'b0}, // R5
        {8'h0A, 2'b10, 1'b0, 1'b0, 2'd3, 1'b0, 4'd0,  1'b1}, // R6
        {8'h0C, 2'b00, 1'b1, 1'b0, 2'd0, 1'b0, 4'd0,  1'b1}, // R6
        {8'h0B, 2'b00, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0,  1'b0}, // R5
        {8'hFF, 2'b10, 1'b0, 1'b1, 2'd0, 1'b0, 4'd0,  1'b0}  // R5
    };

    task automatic check(input string req, input logic v, input logic [3:0] c, input logic u);
        n_chk++;
        if (cyc_valid !== v || cyc_count !== c || cyc_unsup !== u) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b count=%0d unsup=%0b, expected valid=%0b count=%0d unsup=%0b",
                     req, cyc_valid, cyc_count, cyc_unsup, v, c, u);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R9 reset", 1'b0, 4'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle after reset", 1'b0, 4'd0, 1'b0);

        // back-to-back stream through the table (R7)
        for (int i = 0; i < NV; i++) begin
            req_valid       = 1'b1;
            req_tag         = VEC[i][19:12];
            req_width       = VEC[i][11:10];
            req_seq         = VEC[i][9];
            disp_hdraw      = VEC[i][8];
            cart_first_sel  = VEC[i][7:6];
            cart_second_sel = VEC[i][5];
            @(negedge clk);
            check($sformatf("R7 vector %0d", i), 1'b1, VEC[i][4:1], VEC[i][0]);
        end

        // gap: result must drop (R8)
        req_valid = 1'b0;
        req_tag   = 8'h0A;
        @(negedge clk);
        check("R8 gap after stream", 1'b0, 4'd0, 1'b0);
        @(negedge clk);
        check("R8 second idle cycle", 1'b0, 4'd0, 1'b0);

        // single isolated request (R7, R3 worst case)
        req_valid = 1'b1; req_tag = 8'h08; req_width = 2'b10; req_seq = 1'b0;
        cart_first_sel = 2'd3; cart_second_sel = 1'b0;
        @(negedge clk);
        check("R7 isolated request R3 worst case", 1'b1, 4'd10, 1'b0);
        req_valid = 1'b0;
        @(negedge clk);
        check("R8 drain", 1'b0, 4'd0, 1'b0);

        // reset while a result is presented (R9)
        req_valid = 1'b1; req_tag = 8'h0C;
        @(negedge clk);
        check("R6 before reset", 1'b1, 4'd0, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R9 async reset", 1'b0, 4'd0, 1'b0);
        @(negedge clk);
        check("R9 reset held with request", 1'b0, 4'd0, 1'b0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset release", 1'b0, 4'd0, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule